// File: doc/BRIEF.md
# Filtered Quadrature Axis Counter

This block serves one motion axis. It accepts the raw A, B and index (Z) lines from an incremental encoder. Each line passes through a two-flop synchronizer and then a glitch filter. The filter samples at one of four selectable rates, and those rates come from a divider of the system clock. The filtered A/B pair is decoded at every edge, so each edge moves a 24-bit two's complement position up or down by one. Each such step also raises a single-cycle event that a nearby timestamp capture unit can use.

The position can be overwritten with an externally assembled 24-bit preset value in two ways. The first is a software load bit, which acts only on its rising edge. The second is the index pulse, when index preset is enabled. An index-sense flag records each index pulse until a read strobe clears it. The host bus decode and snapshot holding registers sit outside this block.

Top module: `qaxis_counter`

## Requirements
- R1: After reset, position is 0, idxFlag is 0 and countEvent is 0.
- R2: With the filtered state written {A,B}, the sequence 00→10→11→01→00 increments position by one per edge, and the reverse sequence 00→01→11→10→00 decrements it by one per edge.
- R3: Position is 24-bit two's complement and wraps: one up step from 0x7FFFFF gives 0x800000, and one down step from 0x000000 gives 0xFFFFFF.
- R4: A change in which A and B both flip at once leaves position unchanged and produces no countEvent.
- R5: rateSel picks the filter tick period: 0 → DIV_RATE0, 1 → DIV_RATE1, 2 → DIV_RATE2, 3 → DIV_RATE3 system clocks (nominally 1, 2.5, 5 and 10 MHz). An input level that lasts fewer clocks than the selected tick period never reaches the decoder.
- R6: An input level held for at least two tick periods of the selected rate is accepted and counted.
- R7: A 0→1 transition of loadBit loads presetVal into position. Keeping loadBit high causes no further load, even if presetVal changes.
- R8: While idxPresetEn is 1, a rising edge of the filtered Z line loads presetVal into position. While idxPresetEn is 0, the index does not alter position.
- R9: idxFlag is set by every filtered Z rising edge, whether or not idxPresetEn is set. A one-cycle idxRead pulse clears it, and if both happen in the same cycle, the set takes priority.
- R10: countEvent is a one-cycle pulse, high in exactly the cycle where position shows a ±1 step. Loads never raise it, and position never changes without a step or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Raw encoder channel A |
| encB | input | 1 | Raw encoder channel B |
| encZ | input | 1 | Raw encoder index |
| rateSel | input | 2 | Filter rate select |
| presetVal | input | W | Preset value for loads |
| loadBit | input | 1 | Software load request (rising edge acts) |
| idxPresetEn | input | 1 | Allow index pulse to load presetVal |
| idxRead | input | 1 | Read strobe that clears idxFlag |
| position | output | W | Signed position count |
| idxFlag | output | 1 | Index seen since last read |
| countEvent | output | 1 | One-cycle pulse per counted step |

## Verification
The assertions assume that loadBit, idxRead, idxPresetEn and presetVal are synchronous to clk. They also assume that the raw encoder lines change no faster than the filter can pass distinct states. Under those conditions, each position change can be traced to exactly one step or one load. The stimulus changes every input just after the falling clock edge. Each legal encoder step is held for more than three tick periods of the current rate, and a glitch is always held for one clock less than a tick period, so every pattern falls clearly on the accept or the reject side. idxRead is only ever a single-cycle pulse.

// File: rtl/qaxis_pkg.sv
package qaxis_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic loadPos;
    logic idxEdge;
  } axisStrobe_t;
endpackage

// File: rtl/qaxis_ctl.sv
module qaxis_ctl
  import qaxis_pkg::*;
#(
  parameter int DIV_RATE0 = 250,
  parameter int DIV_RATE1 = 100,
  parameter int DIV_RATE2 = 50,
  parameter int DIV_RATE3 = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        encA,
  input  logic        encB,
  input  logic        encZ,
  input  logic [1:0]  rateSel,
  input  logic        loadBit,
  input  logic        idxPresetEn,
  output axisStrobe_t strb
);
  localparam int LINES = 3;
  localparam int MAX01 = (DIV_RATE0 > DIV_RATE1) ? DIV_RATE0 : DIV_RATE1;
  localparam int MAX23 = (DIV_RATE2 > DIV_RATE3) ? DIV_RATE2 : DIV_RATE3;
  localparam int DIV_MAX = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W = $clog2(DIV_MAX + 1);

  // divider producing the filter sample tick
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLast;
  logic             tick;

  always_comb begin
    unique case (rateSel)
      2'd0:    divLast = CNT_W'(DIV_RATE0 - 1);
      2'd1:    divLast = CNT_W'(DIV_RATE1 - 1);
      2'd2:    divLast = CNT_W'(DIV_RATE2 - 1);
      default: divLast = CNT_W'(DIV_RATE3 - 1);
    endcase
  end

  assign tick = (divCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // synchronizer and glitch filter per line: bit0 A, bit1 B, bit2 Z
  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] filt;
  logic [LINES-1:0] filtPrev;

  assign rawIn = {encZ, encB, encA};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic syncA, syncB, sampPrev, filtQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA    <= 1'b0;
        syncB    <= 1'b0;
        sampPrev <= 1'b0;
        filtQ    <= 1'b0;
      end else begin
        syncA <= rawIn[i];
        syncB <= syncA;
        if (tick) begin
          sampPrev <= syncB;
          if (syncB == sampPrev) filtQ <= syncB;
        end
      end
    end
    assign filt[i] = filtQ;
  end

  logic loadPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtPrev <= '0;
      loadPrev <= 1'b0;
    end else begin
      filtPrev <= filt;
      loadPrev <= loadBit;
    end
  end

  // quadrature decode on {A,B}
  logic [1:0] abOld, abNew;
  logic       up, dn;
  assign abOld = {filtPrev[0], filtPrev[1]};
  assign abNew = {filt[0], filt[1]};

  always_comb begin
    up = 1'b0;
    dn = 1'b0;
    unique case ({abOld, abNew})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: up = 1'b1;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: dn = 1'b1;
      default: ;
    endcase
  end

  logic zRise, swRise;
  assign zRise  = filt[2] & ~filtPrev[2];
  assign swRise = loadBit & ~loadPrev;

  assign strb.stepUp  = up;
  assign strb.stepDn  = dn;
  assign strb.loadPos = swRise | (idxPresetEn & zRise);
  assign strb.idxEdge = zRise;
endmodule

// File: rtl/qaxis_dp.sv
module qaxis_dp
  import qaxis_pkg::*;
#(
  parameter int W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  axisStrobe_t strb,
  input  logic [W-1:0] presetVal,
  input  logic        idxRead,
  output logic [W-1:0] position,
  output logic        idxFlag,
  output logic        countEvent
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      position   <= '0;
      countEvent <= 1'b0;
    end else if (strb.loadPos) begin
      position   <= presetVal;
      countEvent <= 1'b0;
    end else if (strb.stepUp) begin
      position   <= position + 1'b1;
      countEvent <= 1'b1;
    end else if (strb.stepDn) begin
      position   <= position - 1'b1;
      countEvent <= 1'b1;
    end else begin
      countEvent <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxFlag <= 1'b0;
    else if (strb.idxEdge) idxFlag <= 1'b1;
    else if (idxRead) idxFlag <= 1'b0;
  end
endmodule

// File: rtl/qaxis_counter.sv
module qaxis_counter
  import qaxis_pkg::*;
#(
  parameter int W = 24,
  parameter int DIV_RATE0 = 250,
  parameter int DIV_RATE1 = 100,
  parameter int DIV_RATE2 = 50,
  parameter int DIV_RATE3 = 25
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         encA,
  input  logic         encB,
  input  logic         encZ,
  input  logic [1:0]   rateSel,
  input  logic [W-1:0] presetVal,
  input  logic         loadBit,
  input  logic         idxPresetEn,
  input  logic         idxRead,
  output logic [W-1:0] position,
  output logic         idxFlag,
  output logic         countEvent
);
  axisStrobe_t strb;

  qaxis_ctl #(
    .DIV_RATE0(DIV_RATE0), .DIV_RATE1(DIV_RATE1),
    .DIV_RATE2(DIV_RATE2), .DIV_RATE3(DIV_RATE3)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encZ(encZ),
    .rateSel(rateSel), .loadBit(loadBit), .idxPresetEn(idxPresetEn),
    .strb(strb)
  );

  qaxis_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .presetVal(presetVal),
    .idxRead(idxRead), .position(position), .idxFlag(idxFlag),
    .countEvent(countEvent)
  );
endmodule

// File: rtl/qaxis_counter_chk.sv
module qaxis_counter_chk
  import qaxis_pkg::*;
#(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rstN,
  input logic         loadBit,
  input logic         idxPresetEn,
  input logic         idxRead,
  input logic [W-1:0] presetVal,
  input logic [W-1:0] position,
  input logic         idxFlag,
  input logic         countEvent,
  input axisStrobe_t  strb
);
  // R10
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    countEvent |-> ((position - $past(position)) == W'(1) ||
                    (position - $past(position)) == {W{1'b1}}));

  // R10
  no_silent_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (position != $past(position)) |-> (countEvent || $past(strb.loadPos)));

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadPos) |-> (position == $past(presetVal) && !countEvent));

  // R7
  held_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadBit && $past(loadBit) && !idxPresetEn) |-> !strb.loadPos);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.idxEdge) |-> idxFlag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(idxRead) && !$past(strb.idxEdge)) |-> !idxFlag);

  // R2
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDn}));
endmodule

bind qaxis_counter qaxis_counter_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .loadBit(loadBit), .idxPresetEn(idxPresetEn),
  .idxRead(idxRead), .presetVal(presetVal), .position(position),
  .idxFlag(idxFlag), .countEvent(countEvent), .strb(strb)
);

// File: tb/qaxis_counter_tb.sv
module qaxis_counter_tb_top;
  localparam int W = 24;
  localparam int D0 = 20, D1 = 8, D2 = 4, D3 = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         encA = 1'b0, encB = 1'b0, encZ = 1'b0;
  logic [1:0]   rateSel = 2'd0;
  logic [W-1:0] presetVal = '0;
  logic         loadBit = 1'b0, idxPresetEn = 1'b0, idxRead = 1'b0;
  logic [W-1:0] position;
  logic         idxFlag, countEvent;

  int checks = 0;
  int errors = 0;
  int evCount = 0;
  bit done = 1'b0;
  logic [W-1:0] expPos = '0;
  logic [1:0]   st = 2'b00;

  always #2 clk = ~clk;

  qaxis_counter #(.W(W), .DIV_RATE0(D0), .DIV_RATE1(D1),
                  .DIV_RATE2(D2), .DIV_RATE3(D3)) dut_i (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encZ(encZ),
    .rateSel(rateSel), .presetVal(presetVal), .loadBit(loadBit),
    .idxPresetEn(idxPresetEn), .idxRead(idxRead), .position(position),
    .idxFlag(idxFlag), .countEvent(countEvent)
  );

  always @(negedge clk) if (rstN && countEvent) evCount++;

  function automatic int divOf(logic [1:0] r);
    case (r)
      2'd0: return D0;
      2'd1: return D1;
      2'd2: return D2;
      default: return D3;
    endcase
  endfunction

  function automatic logic [1:0] upNext(logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] dnNext(logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int holdT();
    return 3 * divOf(rateSel) + 8;
  endfunction

  task automatic driveAB(logic [1:0] s, int hold);
    @(negedge clk);
    encA = s[1];
    encB = s[0];
    st = s;
    waitCyc(hold);
  endtask

  task automatic stepUp();
    driveAB(upNext(st), holdT());
    expPos = expPos + 1'b1;
  endtask

  task automatic stepDn();
    driveAB(dnNext(st), holdT());
    expPos = expPos - 1'b1;
  endtask

  task automatic doLoad(logic [W-1:0] v);
    @(negedge clk);
    presetVal = v;
    loadBit = 1'b1;
    waitCyc(3);
    loadBit = 1'b0;
    waitCyc(2);
    expPos = v;
  endtask

  task automatic zPulse();
    @(negedge clk);
    encZ = 1'b1;
    waitCyc(holdT());
    encZ = 1'b0;
    waitCyc(holdT());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ev0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    // R1
    chk("R1 position", 32'(position), 32'h0);
    chk("R1 idxFlag", 32'(idxFlag), 32'h0);
    chk("R1 countEvent", 32'(countEvent), 32'h0);

    for (int r = 0; r < 4; r++) begin
      rateSel = 2'(r);
      waitCyc(holdT());
      ev0 = evCount;
      for (int k = 0; k < 8; k++) begin
        stepUp();
        chk("R2 up", 32'(position), 32'(expPos));
      end
      for (int k = 0; k < 5; k++) begin
        stepDn();
        chk("R2 down", 32'(position), 32'(expPos));
      end
      // R10 one event per step
      chk("R10 events", 32'(evCount - ev0), 32'd13);
      // R5 glitch on A then B, each one clock shorter than a tick period
      ev0 = evCount;
      @(negedge clk); encA = ~encA;
      waitCyc(divOf(rateSel) - 1);
      encA = ~encA;
      waitCyc(holdT());
      chk("R5 glitch A", 32'(position), 32'(expPos));
      @(negedge clk); encB = ~encB;
      waitCyc(divOf(rateSel) - 1);
      encB = ~encB;
      waitCyc(holdT());
      chk("R5 glitch B", 32'(position), 32'(expPos));
      chk("R5 no event", 32'(evCount - ev0), 32'd0);
      // R4 both lines flip together
      driveAB(~st, holdT());
      chk("R4 illegal", 32'(position), 32'(expPos));
      chk("R4 no event", 32'(evCount - ev0), 32'd0);
      stepUp();
      chk("R4 resume", 32'(position), 32'(expPos));
    end

    // R6 held exactly two tick periods at slowest rate
    rateSel = 2'd0;
    driveAB(upNext(st), 2 * D0);
    expPos = expPos + 1'b1;
    waitCyc(D0 + 8);
    chk("R6 two periods", 32'(position), 32'(expPos));

    // R3 wrap both ways
    doLoad(24'h7FFFFF);
    chk("R3 load", 32'(position), 32'h7FFFFF);
    stepUp();
    chk("R3 wrap up", 32'(position), 32'h800000);
    doLoad(24'h000000);
    stepDn();
    chk("R3 wrap down", 32'(position), 32'hFFFFFF);

    // R7 held load bit does not reload; loads do not raise countEvent
    ev0 = evCount;
    @(negedge clk);
    presetVal = 24'h123456;
    loadBit = 1'b1;
    waitCyc(4);
    chk("R7 load", 32'(position), 32'h123456);
    presetVal = 24'h0ABCDE;
    waitCyc(10);
    chk("R7 held", 32'(position), 32'h123456);
    loadBit = 1'b0;
    waitCyc(4);
    chk("R10 load silent", 32'(evCount - ev0), 32'd0);
    expPos = 24'h123456;

    // R8 and R9 index preset and flag
    rateSel = 2'd3;
    presetVal = 24'h00C0DE;
    idxPresetEn = 1'b1;
    zPulse();
    expPos = 24'h00C0DE;
    chk("R8 index load", 32'(position), 32'(expPos));
    chk("R9 flag set", 32'(idxFlag), 32'h1);
    @(negedge clk); idxRead = 1'b1;
    @(negedge clk); idxRead = 1'b0;
    chk("R9 flag cleared", 32'(idxFlag), 32'h0);
    idxPresetEn = 1'b0;
    presetVal = 24'h555555;
    zPulse();
    chk("R8 index disabled", 32'(position), 32'(expPos));
    chk("R9 flag set again", 32'(idxFlag), 32'h1);
    stepUp();
    chk("R2 after index", 32'(position), 32'(expPos));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule